// File: doc/BRIEF.md
# GPI Edge Detect and Event Logger

This block watches a bank of general-purpose input lines and reports each filtered level change in one of two ways. In the first, the change sets a per-pin interrupt flag. In the second, the change appends a record to an on-chip event queue. Every line first passes a two-flop synchronizer and a debounce counter. The masked, filtered levels then feed an event-driven scan controller, which does nothing until some enabled level differs from its last recorded snapshot. On such a difference the controller runs one scan and returns to rest at once.

The scan controller has three states. `ST_IDLE` waits, and its transition *level differs* leads to `ST_SCAN`. `ST_SCAN` lasts one cycle: it records the new snapshot and raises interrupt flags for the pins in flag mode. Its transition *event pins changed* leads to `ST_PUSH`, and its transition *no event pins* leads back to `ST_IDLE`. `ST_PUSH` writes one queue record per clock, lowest pin first. Its transition *more pending* stays in `ST_PUSH`, and its transition *last record* returns to `ST_IDLE`.

Software reaches the block through an 8-bit register port with a 4-bit address. Per-pin settings are split into a low bank (pins 1 to 8) and a high bank (pins 9 and up). In the address map, bit 0 selects the bank and bits 3:1 select the group.

Top module: `gpi_event_logger`

## Requirements
- R1: After reset, the level registers (0x8, 0x9), the queue count (0xD) and the summary status (0xC) read 0, and both interrupt outputs are low.
- R2: A pin whose input-enable bit is 0 reads 0 in its level register and raises no flag and no queue record. Input enable is at 0x0 (bits 7:0 = pins 1 to 8) and 0x1 (bits 1:0 = pins 9 and 10).
- R3: A raw change that lasts fewer than DEB_CYCLES clocks leaves the filtered level unchanged. A change held well beyond DEB_CYCLES appears in the level registers.
- R4: Register 0x8 bit k holds the filtered level of pin k+1 for k = 0..7. Register 0x9 bit j holds the filtered level of pin j+9.
- R5: For a pin in flag mode, polarity bit 1 means a rising edge sets its flag and polarity bit 0 means a falling edge sets it. The opposite edge leaves the flag clear. Polarity is at 0x4 and 0x5, with the same bank layout as input enable.
- R6: A flag is set only when the pin's interrupt-enable bit (0x2 and 0x3) is 1. Writing 1 to a flag bit (0xA and 0xB) clears it. `gpi_irq_o` is high exactly while any flag is set, and it is mirrored in status 0xC bit 1.
- R7: A pin whose event bit (0x6 and 0x7) is 1 never sets a flag. Each of its edges instead adds a queue record and raises the event interrupt, which is shown in status 0xC bit 0 and drives `evt_irq_o`.
- R8: A record byte is {active, id[6:0]}. The active bit is 1 for a rising edge and 0 for a falling edge, and id = 37 + (pin number − 1).
- R9: When several event pins change in one scan, their records enter the queue in ascending pin order.
- R10: A read of 0xE returns the oldest record, removes it, and lowers the count at 0xD by one. A read of 0xE with an empty queue returns 0 and leaves the count at 0.
- R11: The queue holds 16 records. An event that arrives while the queue is full is dropped and sets the overflow bit (0xC bit 2, which also drives `evt_irq_o`). The overflow bit is cleared by writing 1 to it, and the 16 stored records are preserved.
- R12: Writing 1 to 0xC bit 0 clears the event interrupt only when the queue count is 0. Otherwise the interrupt stays set.
- R13: The scanner sees both edges of a pulse that lasts just a few clocks longer than the debounce period, and it logs a press and then a release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (pops the queue at 0xE) |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| gpi_i | input | NUM_PINS | Raw input lines |
| gpi_irq_o | output | 1 | Any per-pin flag set |
| evt_irq_o | output | 1 | Event pending or queue overflow |

## Verification
The bench sweeps every pin through both polarities and both edges. A swapped polarity sense, or an off-by-one in the bank split, would show up as a flag on the wrong edge or a bit in the wrong register. It fills the queue with twenty events at once. This checks that records come out lowest pin first, that the seventeenth event onward is dropped without harming the stored records, and that a pop from the empty queue yields 0 rather than a stale record. It also drives a glitch one clock shorter than the debounce period, which a filter that counted one cycle short would pass. A pulse barely longer than that period must produce a release record, which a scanner that waits between scans would miss. Finally, it tries to clear the event interrupt while records remain, which a design that ignored the count would allow.

// File: rtl/gpi_pkg.sv
package gpi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_PUSH
    } scan_state_t;

    // register groups: addr[3:1] selects the group, addr[0] the bank
    localparam logic [2:0] GRP_INEN = 3'd0;
    localparam logic [2:0] GRP_IEN  = 3'd1;
    localparam logic [2:0] GRP_POL  = 3'd2;
    localparam logic [2:0] GRP_EVEN = 3'd3;
    localparam logic [2:0] GRP_LVL  = 3'd4;
    localparam logic [2:0] GRP_FLG  = 3'd5;

    localparam logic [3:0] ADR_STAT = 4'hC;
    localparam logic [3:0] ADR_CNT  = 4'hD;
    localparam logic [3:0] ADR_POP  = 4'hE;

endpackage

// File: rtl/gpi_debounce.sv
module gpi_debounce #(
    parameter int DEB_CYCLES = 8750
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            cnt_q  <= '0;
            filt_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == filt_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
                filt_o <= sync_q[1];
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R3
    deb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (filt_o != $past(filt_o)) |-> (filt_o == $past(sync_q[1])));

endmodule

// File: rtl/gpi_event_fifo.sv
module gpi_event_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       push_i,
    input  logic [W-1:0]               din_i,
    input  logic                       pop_i,
    output logic [W-1:0]               dout_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic                       drop_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic          full, do_push, do_pop;

    assign full    = (count_o == CW'(DEPTH));
    assign do_pop  = pop_i && (count_o != '0);
    assign do_push = push_i && (!full || do_pop);
    assign drop_o  = push_i && !do_push;
    assign dout_o  = mem_q[rp_q];

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[wp_q] <= din_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wp_q    <= '0;
            rp_q    <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count_o <= count_o + 1'b1;
                2'b01:   count_o <= count_o - 1'b1;
                default: count_o <= count_o;
            endcase
        end
    end

    // R11
    fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        count_o <= CW'(DEPTH));

    // R10
    cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1)
        || (count_o == $past(count_o) - 1'b1));

endmodule

// File: rtl/gpi_scan_ctrl.sv
module gpi_scan_ctrl
    import gpi_pkg::*;
#(
    parameter int N       = 10,
    parameter int ID_BASE = 37
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] ien_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] even_i,
    output logic [N-1:0] flag_set_o,
    output logic         push_o,
    output logic [7:0]   rec_o
);
    localparam int IW = $clog2(N);

    scan_state_t   state_q, state_d;
    logic [N-1:0]  prev_q, cur_q, pend_q, pend_after, chg;
    logic [IW-1:0] sel;

    assign chg = lvl_i ^ prev_q;

    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_q[i]) sel = IW'(i);
        end
        pend_after = pend_q & ~(N'(1) << sel);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (chg != '0) state_d = ST_SCAN;
            ST_SCAN: state_d = ((chg & even_i) != '0) ? ST_PUSH : ST_IDLE;
            ST_PUSH: if (pend_after == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= '0;
            cur_q  <= '0;
            pend_q <= '0;
        end else begin
            unique case (state_q)
                ST_SCAN: begin
                    prev_q <= lvl_i;
                    cur_q  <= lvl_i;
                    pend_q <= chg & even_i;
                end
                ST_PUSH: pend_q <= pend_after;
                default: ;
            endcase
        end
    end

    always_comb begin
        flag_set_o = '0;
        push_o     = 1'b0;
        rec_o      = '0;
        unique case (state_q)
            ST_SCAN: flag_set_o = chg & ien_i & ~even_i & ~(lvl_i ^ pol_i);
            ST_PUSH: begin
                push_o = 1'b1;
                rec_o  = {cur_q[sel], 7'(ID_BASE) + 7'(sel)};
            end
            default: ;
        endcase
    end

    // R13
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && lvl_i == prev_q) |=> (state_q == ST_IDLE));

    // R9
    push_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_PUSH && $past(state_q) == ST_PUSH) |-> (sel > $past(sel)));

endmodule

// File: rtl/gpi_event_logger.sv
module gpi_event_logger
    import gpi_pkg::*;
#(
    parameter int NUM_PINS   = 10,
    parameter int DEB_CYCLES = 8750,
    parameter int FIFO_DEPTH = 16,
    parameter int ID_BASE    = 37
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [3:0]          addr_i,
    input  logic [7:0]          wdata_i,
    input  logic                wr_en_i,
    input  logic                rd_en_i,
    output logic [7:0]          rdata_o,
    input  logic [NUM_PINS-1:0] gpi_i,
    output logic                gpi_irq_o,
    output logic                evt_irq_o
);
    localparam int N  = NUM_PINS;
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [N-1:0]  filt, lvl, inen_q, ien_q, pol_q, even_q, flag_q, flag_set, flag_clr;
    logic          push, pop, drop, evt_q, ovf_q;
    logic [7:0]    rec, head;
    logic [CW-1:0] count;
    logic [2:0]    grp;

    assign grp = addr_i[3:1];

    for (genvar g = 0; g < N; g++) begin : g_deb
        gpi_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .raw_i (gpi_i[g]),
            .filt_o(filt[g])
        );
    end

    assign lvl = filt & inen_q;

    gpi_scan_ctrl #(.N(N), .ID_BASE(ID_BASE)) u_scan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .lvl_i     (lvl),
        .ien_i     (ien_q),
        .pol_i     (pol_q),
        .even_i    (even_q),
        .flag_set_o(flag_set),
        .push_o    (push),
        .rec_o     (rec)
    );

    gpi_event_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .push_i (push),
        .din_i  (rec),
        .pop_i  (pop),
        .dout_o (head),
        .count_o(count),
        .drop_o (drop)
    );

    assign pop = rd_en_i && (addr_i == ADR_POP) && (count != '0);

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flag_clr[i] = wr_en_i && grp == GRP_FLG && addr_i[0] == (i >= 8) && wdata_i[i % 8];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            inen_q <= '0;
            ien_q  <= '0;
            pol_q  <= '0;
            even_q <= '0;
            flag_q <= '0;
            evt_q  <= 1'b0;
            ovf_q  <= 1'b0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (wr_en_i && addr_i[0] == (i >= 8)) begin
                    if (grp == GRP_INEN) inen_q[i] <= wdata_i[i % 8];
                    if (grp == GRP_IEN)  ien_q[i]  <= wdata_i[i % 8];
                    if (grp == GRP_POL)  pol_q[i]  <= wdata_i[i % 8];
                    if (grp == GRP_EVEN) even_q[i] <= wdata_i[i % 8];
                end
            end
            flag_q <= (flag_q & ~flag_clr) | flag_set;
            if (push)
                evt_q <= 1'b1;
            else if (wr_en_i && addr_i == ADR_STAT && wdata_i[0] && count == '0)
                evt_q <= 1'b0;
            if (drop)
                ovf_q <= 1'b1;
            else if (wr_en_i && addr_i == ADR_STAT && wdata_i[2])
                ovf_q <= 1'b0;
        end
    end

    function automatic logic [7:0] bank8(input logic [N-1:0] v, input logic hi);
        logic [7:0] o;
        o = '0;
        for (int j = 0; j < 8; j++) begin
            if (int'(hi) * 8 + j < N) o[j] = v[int'(hi) * 8 + j];
        end
        return o;
    endfunction

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADR_STAT: rdata_o = {5'd0, ovf_q, gpi_irq_o, evt_q};
            ADR_CNT:  rdata_o = 8'(count);
            ADR_POP:  rdata_o = (count != '0) ? head : 8'd0;
            default: begin
                unique case (grp)
                    GRP_INEN: rdata_o = bank8(inen_q, addr_i[0]);
                    GRP_IEN:  rdata_o = bank8(ien_q, addr_i[0]);
                    GRP_POL:  rdata_o = bank8(pol_q, addr_i[0]);
                    GRP_EVEN: rdata_o = bank8(even_q, addr_i[0]);
                    GRP_LVL:  rdata_o = bank8(lvl, addr_i[0]);
                    GRP_FLG:  rdata_o = bank8(flag_q, addr_i[0]);
                    default:  rdata_o = '0;
                endcase
            end
        endcase
    end

    assign gpi_irq_o = |flag_q;
    assign evt_irq_o = evt_q | ovf_q;

    // R6
    flag_need_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q & ~$past(flag_q) & ~$past(ien_q)) == '0);

    // R7
    evt_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_q & ~$past(flag_q) & $past(even_q)) == '0);

    // R12
    evt_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(evt_q) && $past(count) != '0) |-> evt_q);

endmodule

// File: tb/gpi_event_logger_bench.sv
`timescale 1ns/1ps
module gpi_event_logger_bench;
    localparam int N   = 10;
    localparam int DEB = 4;
    localparam int IDB = 37;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   rdata;
    logic [N-1:0] gpi = '0;
    logic         gpi_irq, evt_irq;
    int           total = 0;
    int           bad = 0;

    always #4 clk = ~clk;

    gpi_event_logger #(.NUM_PINS(N), .DEB_CYCLES(DEB), .FIFO_DEPTH(16), .ID_BASE(IDB)) u_gpi_event_logger (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_en_i(wr_en),
        .rd_en_i(rd_en), .rdata_o(rdata), .gpi_i(gpi), .gpi_irq_o(gpi_irq), .evt_irq_o(evt_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = int'(rdata);
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic pins(input logic [N-1:0] v);
        @(negedge clk); gpi = v;
    endtask

    task automatic settle();
        repeat (30) @(posedge clk);
        #1;
    endtask

    task automatic rd_flags(output int f);
        int lo, hi;
        rd(4'hA, lo); rd(4'hB, hi);
        f = (hi << 8) | lo;
    endtask

    task automatic clr_flags();
        wr(4'hA, 8'hFF); wr(4'hB, 8'h03);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d, f;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(4'h8, d); chk("R1 level A", d, 0);
        rd(4'h9, d); chk("R1 level B", d, 0);
        rd(4'hD, d); chk("R1 count", d, 0);
        rd(4'hC, d); chk("R1 status", d, 0);
        chk("R1 gpi_irq", int'(gpi_irq), 0);
        chk("R1 evt_irq", int'(evt_irq), 0);

        wr(4'h0, 8'hFF); wr(4'h1, 8'h03);

        // R3 glitch one cycle shorter than the debounce period
        pins(10'h001);
        repeat (DEB - 1) @(negedge clk);
        gpi = '0;
        settle();
        rd(4'h8, d); chk("R3 glitch filtered", d, 0);
        pins(10'h001); settle();
        rd(4'h8, d); chk("R3 held level", d, 1);
        pins('0); settle();

        // R4 bank layout sweep
        for (int p = 0; p < N; p++) begin
            pins(N'(1) << p); settle();
            rd(4'h8, d); chk("R4 level A", d, (1 << p) & 8'hFF);
            rd(4'h9, d); chk("R4 level B", d, (1 << p) >> 8);
            pins('0); settle();
        end

        // R2 disabled pin
        wr(4'h2, 8'hFF); wr(4'h3, 8'h03);
        wr(4'h4, 8'hFF); wr(4'h5, 8'h03);
        wr(4'h1, 8'h00);
        pins(10'h200); settle();
        rd(4'h9, d); chk("R2 disabled level", d, 0);
        rd_flags(f); chk("R2 disabled flag", f, 0);
        chk("R2 disabled gpi_irq", int'(gpi_irq), 0);
        pins('0); settle();
        wr(4'h1, 8'h03);

        // R5 R6 polarity sweep
        for (int pol = 0; pol < 2; pol++) begin
            wr(4'h4, pol != 0 ? 8'hFF : 8'h00);
            wr(4'h5, pol != 0 ? 8'h03 : 8'h00);
            for (int p = 0; p < N; p++) begin
                pins(N'(1) << p); settle();
                rd_flags(f); chk("R5 rise flag", f, pol != 0 ? (1 << p) : 0);
                chk("R6 gpi_irq rise", int'(gpi_irq), pol);
                clr_flags();
                chk("R6 w1c clear", int'(gpi_irq), 0);
                pins('0); settle();
                rd_flags(f); chk("R5 fall flag", f, pol != 0 ? 0 : (1 << p));
                chk("R6 gpi_irq fall", int'(gpi_irq), 1 - pol);
                clr_flags();
            end
        end

        // R6 interrupt-enable gating
        wr(4'h2, 8'h00); wr(4'h3, 8'h00);
        pins(10'h008); settle();
        pins('0); settle();
        rd_flags(f); chk("R6 gated flag", f, 0);
        chk("R6 gated gpi_irq", int'(gpi_irq), 0);
        wr(4'h2, 8'hFF); wr(4'h3, 8'h03);
        wr(4'h4, 8'hFF); wr(4'h5, 8'h03);

        // R7 R8 event mode sweep
        wr(4'h6, 8'hFF); wr(4'h7, 8'h03);
        for (int p = 0; p < N; p++) begin
            pins(N'(1) << p); settle();
            rd(4'hD, d); chk("R7 count after press", d, 1);
            rd_flags(f); chk("R7 no flag", f, 0);
            chk("R7 evt_irq", int'(evt_irq), 1);
            rd(4'hE, d); chk("R8 press record", d, 128 + IDB + p);
            pins('0); settle();
            rd(4'hE, d); chk("R8 release record", d, IDB + p);
            rd(4'hD, d); chk("R10 count after pops", d, 0);
            wr(4'hC, 8'h01);
            chk("R12 clear when empty", int'(evt_irq), 0);
        end

        // R12 clear refused while records remain
        pins(10'h001); settle();
        wr(4'hC, 8'h01);
        chk("R12 clear refused", int'(evt_irq), 1);
        rd(4'hE, d);
        wr(4'hC, 8'h01);
        chk("R12 clear accepted", int'(evt_irq), 0);
        pins('0); settle();
        rd(4'hE, d); chk("R8 release pin1", d, IDB);
        wr(4'hC, 8'h01);

        // R9 simultaneous changes in ascending order
        pins('1); settle();
        rd(4'hD, d); chk("R9 count", d, N);
        for (int p = 0; p < N; p++) begin
            rd(4'hE, d); chk("R9 press order", d, 128 + IDB + p);
        end
        pins('0); settle();
        for (int p = 0; p < N; p++) begin
            rd(4'hE, d); chk("R9 release order", d, IDB + p);
        end
        wr(4'hC, 8'h01);

        // R11 overflow with twenty events
        pins('1); settle();
        pins('0); settle();
        rd(4'hD, d); chk("R11 count full", d, 16);
        rd(4'hC, d); chk("R11 overflow bit", (d >> 2) & 1, 1);
        chk("R11 evt_irq", int'(evt_irq), 1);
        for (int k = 0; k < 16; k++) begin
            rd(4'hE, d);
            chk("R11 kept record", d, k < N ? 128 + IDB + k : IDB + k - N);
        end
        // R10 empty pop
        rd(4'hE, d); chk("R10 empty pop", d, 0);
        rd(4'hD, d); chk("R10 empty count", d, 0);
        wr(4'hC, 8'h05);
        rd(4'hC, d); chk("R11 overflow cleared", d, 0);
        chk("R11 evt_irq cleared", int'(evt_irq), 0);

        // R13 short pulse gives both edges
        pins(10'h020);
        repeat (DEB + 4) @(negedge clk);
        gpi = '0;
        settle();
        rd(4'hD, d); chk("R13 two records", d, 2);
        rd(4'hE, d); chk("R13 press", d, 128 + IDB + 5);
        rd(4'hE, d); chk("R13 release", d, IDB + 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule